// File: doc/BRIEF.md
# Passive SPI Bus Monitor

This block listens to the four lines of an SPI bus (serial clock, MOSI, MISO and chip select) without ever driving them. It samples the lines with its own faster system clock and rebuilds the full-duplex words that cross the bus. Each finished word comes out as a one-cycle pulse. The pulse carries the MOSI word, the MISO word, a presence flag for each data line, a warning flag and the number of system cycles the word took, so that software can work out the bus bit rate.

Clock polarity, clock phase, chip-select polarity, bit order, word length and which lines are wired up are all run-time inputs. They are copied into a shadow set only while the bus is not selected, or between words when no chip select is wired. Every change of the chip-select level is reported as an event that carries the old and new line levels. A start-up event reports the level seen after reset.

A controller with four states sequences the monitor:
- ST_FILL waits for the input synchronisers to fill and then moves to ST_ANNOUNCE.
- ST_ANNOUNCE issues the start-up event. It goes to ST_SHIFT if chip select is asserted or not wired, and to ST_WAIT otherwise.
- ST_WAIT goes to ST_SHIFT when chip select becomes asserted or is marked not wired.
- ST_SHIFT goes back to ST_WAIT when a wired chip select is no longer asserted.

Sample edges are captured only in ST_SHIFT.

Top module: `spi_bus_monitor`

## Requirements
- R1: The sample edge of the serial clock is the rising edge when `cfg_cpol` equals `cfg_cpha` (modes 0 and 3), and the falling edge otherwise (modes 1 and 2).
- R2: With `cfg_lsb_first`=0, the n-th captured bit of a word lands at bit position len-1-n. With `cfg_lsb_first`=1, it lands at position n.
- R3: A word completes after `cfg_word_len` captured bits. A value of 0, or a value above MAX_WORD (16), selects MAX_WORD. Word bits at and above the length read 0.
- R4: `cfg_cs_act_high`=0 makes a low chip select the asserted level, and `cfg_cs_act_high`=1 makes a high chip select the asserted level. Clock edges seen while chip select is not asserted produce no word.
- R5: Each change of a wired chip-select line produces one `cs_evt_valid` pulse with `cs_evt_prev` and `cs_evt_now` set to the line levels, coded 2'b00 low and 2'b01 high. The change also discards any partly assembled word.
- R6: After reset, exactly one start-up event is produced with `cs_evt_prev`=2'b10 (unknown). `cs_evt_now` gives the line level, or 2'b11 when `cfg_cs_present`=0. With no chip select wired, words are decoded continuously and line changes produce no event.
- R7: A data line marked absent (`cfg_mosi_present` or `cfg_miso_present` = 0) gives an all-zero word and a low `word_mosi_ok` or `word_miso_ok`. A present line gives a high flag.
- R8: `word_warn` is 1 when chip select was not asserted at the first bit of the word. This happens when that bit's clock edge arrives together with the chip-select release. Otherwise `word_warn` is 0.
- R9: `word_cycles` equals the number of system cycles from the first bit's sample up to and including the completing sample. It saturates at 2^24-1.
- R10: Configuration changes made while a word is in progress under an asserted chip select do not affect that word.
- R11: `word_valid` and `cs_evt_valid` are low during reset, and `word_valid` is never high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_cpol | input | 1 | Idle level of the serial clock |
| cfg_cpha | input | 1 | 0: sample on the leading edge, 1: sample on the trailing edge |
| cfg_cs_act_high | input | 1 | 1: chip select asserted when high |
| cfg_lsb_first | input | 1 | 1: first bit is the least significant |
| cfg_word_len | input | 5 | Bits per word; 0 selects MAX_WORD |
| cfg_mosi_present | input | 1 | MOSI line is wired |
| cfg_miso_present | input | 1 | MISO line is wired |
| cfg_cs_present | input | 1 | Chip-select line is wired |
| spi_sclk | input | 1 | Observed serial clock |
| spi_cs | input | 1 | Observed chip select |
| spi_mosi | input | 1 | Observed MOSI line |
| spi_miso | input | 1 | Observed MISO line |
| word_valid | output | 1 | One-cycle pulse: a word has completed |
| word_mosi | output | 16 | Rebuilt MOSI word |
| word_miso | output | 16 | Rebuilt MISO word |
| word_mosi_ok | output | 1 | MOSI word is valid |
| word_miso_ok | output | 1 | MISO word is valid |
| word_warn | output | 1 | First bit was taken while chip select was not asserted |
| word_cycles | output | 24 | System cycles spanned by the word, inclusive |
| cs_evt_valid | output | 1 | One-cycle pulse: chip-select event |
| cs_evt_prev | output | 2 | Previous level: 00 low, 01 high, 10 unknown |
| cs_evt_now | output | 2 | New level: 00 low, 01 high, 11 not wired |

## Verification
Each of the four clock modes is driven by a bench master that changes data on the non-sampling edge. A monitor that samples on the wrong edge therefore picks up the neighbouring bit and returns a different word. Asymmetric byte values, sent once MSB-first and once LSB-first, separate the two bit orders. Word lengths of 12 and 0 (which selects the maximum) show where a word ends. A burst of three bits cut off by a chip-select release, followed by a full word, shows that the partial word is discarded. Patterns sent while chip select is inactive, while a data line is marked absent, while chip select is not wired, and with a configuration change mid-word show that each of these inputs leaves the outputs exactly as the requirements state.

// File: rtl/spi_mon_pkg.sv
package spi_mon_pkg;

    typedef enum logic [1:0] {
        ST_FILL     = 2'd0,
        ST_ANNOUNCE = 2'd1,
        ST_WAIT     = 2'd2,
        ST_SHIFT    = 2'd3
    } mon_state_e;

    typedef enum logic [1:0] {
        CS_LVL_LOW     = 2'b00,
        CS_LVL_HIGH    = 2'b01,
        CS_LVL_UNKNOWN = 2'b10,
        CS_LVL_ABSENT  = 2'b11
    } cs_code_e;

    typedef struct packed {
        logic cpol;
        logic cpha;
        logic cs_act_high;
        logic lsb_first;
        logic mosi_en;
        logic miso_en;
        logic cs_en;
    } mon_cfg_t;

endpackage

// File: rtl/spi_mon_sync.sv
module spi_mon_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage[0] <= '0;
        else        stage[0] <= d;
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage[g] <= '0;
            else        stage[g] <= stage[g-1];
        end
    end

    assign q = stage[STAGES-1];
endmodule

// File: rtl/spi_mon_ctrl.sv
module spi_mon_ctrl
    import spi_mon_pkg::*;
#(
    parameter int MAX_WORD = 16,
    parameter int STAGES   = 2,
    parameter int LEN_W    = $clog2(MAX_WORD + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  mon_cfg_t         cfg_live,
    input  logic [LEN_W-1:0] len_live,
    input  logic             sclk_s,
    input  logic             cs_s,
    input  logic             shift_idle,
    output mon_cfg_t         cfg_sh,
    output logic [LEN_W-1:0] len_sh,
    output logic             capture,
    output logic             flush,
    output logic             warn_first,
    output logic             cs_evt_valid,
    output cs_code_e         cs_evt_prev,
    output cs_code_e         cs_evt_now
);
    localparam int FILL_W = $clog2(STAGES + 2);
    localparam logic [FILL_W-1:0] FILL_LAST = FILL_W'(STAGES);

    mon_state_e        state, state_n;
    logic [FILL_W-1:0] fill_cnt;
    logic              sclk_q, cs_q;
    logic              asserted, rise, fall, sample_edge, cs_moved, upd;

    assign asserted    = (cs_s == cfg_sh.cs_act_high);
    assign rise        = sclk_s & ~sclk_q;
    assign fall        = ~sclk_s & sclk_q;
    assign sample_edge = (cfg_sh.cpol ^ cfg_sh.cpha) ? fall : rise;
    assign cs_moved    = cfg_sh.cs_en && (cs_s != cs_q) &&
                         ((state == ST_WAIT) || (state == ST_SHIFT));
    assign upd         = (state != ST_SHIFT) ||
                         (!cfg_sh.cs_en && shift_idle);

    always_comb begin
        state_n = state;
        unique case (state)
            ST_FILL:     if (fill_cnt == FILL_LAST) state_n = ST_ANNOUNCE;
            ST_ANNOUNCE: state_n = (asserted || !cfg_sh.cs_en) ? ST_SHIFT : ST_WAIT;
            ST_WAIT:     if (asserted || !cfg_sh.cs_en) state_n = ST_SHIFT;
            ST_SHIFT:    if (cfg_sh.cs_en && !asserted) state_n = ST_WAIT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_FILL;
            fill_cnt <= '0;
        end else begin
            state <= state_n;
            if (state == ST_FILL) fill_cnt <= fill_cnt + FILL_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            cs_q   <= 1'b0;
        end else begin
            sclk_q <= sclk_s;
            cs_q   <= cs_s;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_sh <= '0;
            len_sh <= LEN_W'(MAX_WORD);
        end else if (upd) begin
            cfg_sh <= cfg_live;
            if (len_live == '0 || len_live > LEN_W'(MAX_WORD)) len_sh <= LEN_W'(MAX_WORD);
            else                                               len_sh <= len_live;
        end
    end

    assign capture    = (state == ST_SHIFT) && sample_edge;
    assign flush      = cs_moved;
    assign warn_first = cfg_sh.cs_en && !asserted;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_evt_valid <= 1'b0;
            cs_evt_prev  <= CS_LVL_UNKNOWN;
            cs_evt_now   <= CS_LVL_UNKNOWN;
        end else begin
            cs_evt_valid <= 1'b0;
            if (state == ST_ANNOUNCE) begin
                cs_evt_valid <= 1'b1;
                cs_evt_prev  <= CS_LVL_UNKNOWN;
                cs_evt_now   <= !cfg_sh.cs_en ? CS_LVL_ABSENT :
                                (cs_s ? CS_LVL_HIGH : CS_LVL_LOW);
            end else if (cs_moved) begin
                cs_evt_valid <= 1'b1;
                cs_evt_prev  <= cs_q ? CS_LVL_HIGH : CS_LVL_LOW;
                cs_evt_now   <= cs_s ? CS_LVL_HIGH : CS_LVL_LOW;
            end
        end
    end
endmodule

// File: rtl/spi_mon_shifter.sv
module spi_mon_shifter #(
    parameter int MAX_WORD = 16,
    parameter int CNT_W    = 24,
    parameter int LEN_W    = $clog2(MAX_WORD + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic                capture,
    input  logic                warn_in,
    input  logic                lsb_first,
    input  logic [LEN_W-1:0]    word_len,
    input  logic                mosi_en,
    input  logic                miso_en,
    input  logic                mosi_bit,
    input  logic                miso_bit,
    output logic                idle,
    output logic                out_valid,
    output logic [MAX_WORD-1:0] out_mosi,
    output logic [MAX_WORD-1:0] out_miso,
    output logic                out_mosi_ok,
    output logic                out_miso_ok,
    output logic                out_warn,
    output logic [CNT_W-1:0]    out_cycles
);
    logic [LEN_W-1:0]    bit_cnt, base_cnt, pos;
    logic [MAX_WORD-1:0] mosi_acc, miso_acc, base_mosi, base_miso, mask;
    logic [MAX_WORD-1:0] nxt_mosi, nxt_miso;
    logic [CNT_W-1:0]    cyc_cnt, cyc_inc, cyc_now;
    logic                warn_acc, nxt_warn, last;

    always_comb begin
        base_cnt  = clear ? '0 : bit_cnt;
        base_mosi = clear ? '0 : mosi_acc;
        base_miso = clear ? '0 : miso_acc;
        pos       = lsb_first ? base_cnt : LEN_W'(word_len - LEN_W'(1) - base_cnt);
        mask      = MAX_WORD'(1) << pos;
        last      = (LEN_W'(base_cnt + LEN_W'(1)) == word_len);
        nxt_mosi  = base_mosi | ((mosi_en && mosi_bit) ? mask : '0);
        nxt_miso  = base_miso | ((miso_en && miso_bit) ? mask : '0);
        nxt_warn  = (base_cnt == '0) ? warn_in : warn_acc;
        cyc_inc   = (cyc_cnt == '1) ? cyc_cnt : cyc_cnt + CNT_W'(1);
        cyc_now   = (base_cnt == '0) ? CNT_W'(1) : cyc_inc;
    end

    assign idle = (bit_cnt == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt  <= '0;
            mosi_acc <= '0;
            miso_acc <= '0;
            warn_acc <= 1'b0;
            cyc_cnt  <= '0;
        end else if (capture && last) begin
            bit_cnt  <= '0;
            mosi_acc <= '0;
            miso_acc <= '0;
            warn_acc <= 1'b0;
            cyc_cnt  <= '0;
        end else if (capture) begin
            bit_cnt  <= LEN_W'(base_cnt + LEN_W'(1));
            mosi_acc <= nxt_mosi;
            miso_acc <= nxt_miso;
            warn_acc <= nxt_warn;
            cyc_cnt  <= cyc_now;
        end else if (clear) begin
            bit_cnt  <= '0;
            mosi_acc <= '0;
            miso_acc <= '0;
            warn_acc <= 1'b0;
            cyc_cnt  <= '0;
        end else if (bit_cnt != '0) begin
            cyc_cnt  <= cyc_inc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_mosi    <= '0;
            out_miso    <= '0;
            out_mosi_ok <= 1'b0;
            out_miso_ok <= 1'b0;
            out_warn    <= 1'b0;
            out_cycles  <= '0;
        end else begin
            out_valid <= capture && last;
            if (capture && last) begin
                out_mosi    <= nxt_mosi;
                out_miso    <= nxt_miso;
                out_mosi_ok <= mosi_en;
                out_miso_ok <= miso_en;
                out_warn    <= nxt_warn;
                out_cycles  <= cyc_now;
            end
        end
    end
endmodule

// File: rtl/spi_bus_monitor.sv
module spi_bus_monitor
    import spi_mon_pkg::*;
#(
    parameter int MAX_WORD = 16,
    parameter int CNT_W    = 24,
    parameter int STAGES   = 2,
    localparam int LEN_W   = $clog2(MAX_WORD + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_cpol,
    input  logic                cfg_cpha,
    input  logic                cfg_cs_act_high,
    input  logic                cfg_lsb_first,
    input  logic [LEN_W-1:0]    cfg_word_len,
    input  logic                cfg_mosi_present,
    input  logic                cfg_miso_present,
    input  logic                cfg_cs_present,
    input  logic                spi_sclk,
    input  logic                spi_cs,
    input  logic                spi_mosi,
    input  logic                spi_miso,
    output logic                word_valid,
    output logic [MAX_WORD-1:0] word_mosi,
    output logic [MAX_WORD-1:0] word_miso,
    output logic                word_mosi_ok,
    output logic                word_miso_ok,
    output logic                word_warn,
    output logic [CNT_W-1:0]    word_cycles,
    output logic                cs_evt_valid,
    output logic [1:0]          cs_evt_prev,
    output logic [1:0]          cs_evt_now
);
    mon_cfg_t         cfg_live, cfg_sh;
    logic [LEN_W-1:0] len_sh;
    logic [3:0]       lines_s;
    logic             capture, flush, warn_first, shift_idle;
    cs_code_e         evt_prev, evt_now;

    assign cfg_live = '{cpol: cfg_cpol, cpha: cfg_cpha, cs_act_high: cfg_cs_act_high,
                        lsb_first: cfg_lsb_first, mosi_en: cfg_mosi_present,
                        miso_en: cfg_miso_present, cs_en: cfg_cs_present};

    spi_mon_sync #(.W(4), .STAGES(STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({spi_sclk, spi_cs, spi_mosi, spi_miso}),
        .q     (lines_s)
    );

    spi_mon_ctrl #(.MAX_WORD(MAX_WORD), .STAGES(STAGES)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_live     (cfg_live),
        .len_live     (cfg_word_len),
        .sclk_s       (lines_s[3]),
        .cs_s         (lines_s[2]),
        .shift_idle   (shift_idle),
        .cfg_sh       (cfg_sh),
        .len_sh       (len_sh),
        .capture      (capture),
        .flush        (flush),
        .warn_first   (warn_first),
        .cs_evt_valid (cs_evt_valid),
        .cs_evt_prev  (evt_prev),
        .cs_evt_now   (evt_now)
    );

    spi_mon_shifter #(.MAX_WORD(MAX_WORD), .CNT_W(CNT_W)) u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (flush),
        .capture     (capture),
        .warn_in     (warn_first),
        .lsb_first   (cfg_sh.lsb_first),
        .word_len    (len_sh),
        .mosi_en     (cfg_sh.mosi_en),
        .miso_en     (cfg_sh.miso_en),
        .mosi_bit    (lines_s[1]),
        .miso_bit    (lines_s[0]),
        .idle        (shift_idle),
        .out_valid   (word_valid),
        .out_mosi    (word_mosi),
        .out_miso    (word_miso),
        .out_mosi_ok (word_mosi_ok),
        .out_miso_ok (word_miso_ok),
        .out_warn    (word_warn),
        .out_cycles  (word_cycles)
    );

    assign cs_evt_prev = evt_prev;
    assign cs_evt_now  = evt_now;
endmodule

// File: rtl/spi_mon_chk.sv
module spi_mon_chk #(
    parameter int MAX_WORD = 16,
    parameter int CNT_W    = 24
) (
    input logic                clk,
    input logic                rst_n,
    input logic                word_valid,
    input logic [MAX_WORD-1:0] word_mosi,
    input logic [MAX_WORD-1:0] word_miso,
    input logic                word_mosi_ok,
    input logic                word_miso_ok,
    input logic [CNT_W-1:0]    word_cycles,
    input logic                cs_evt_valid,
    input logic [1:0]          cs_evt_prev,
    input logic [1:0]          cs_evt_now
);
    // R7
    absent_mosi_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && !word_mosi_ok) |-> (word_mosi == '0));

    // R7
    absent_miso_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && !word_miso_ok) |-> (word_miso == '0));

    // R9
    cycles_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> (word_cycles != '0));

    // R5
    evt_changes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_evt_valid |-> (cs_evt_prev != cs_evt_now));

    // R6
    absent_only_startup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_evt_valid && cs_evt_now == 2'b11) |-> (cs_evt_prev == 2'b10));

    // R11
    word_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |=> !word_valid);
endmodule

bind spi_bus_monitor spi_mon_chk #(.MAX_WORD(MAX_WORD), .CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .word_valid   (word_valid),
    .word_mosi    (word_mosi),
    .word_miso    (word_miso),
    .word_mosi_ok (word_mosi_ok),
    .word_miso_ok (word_miso_ok),
    .word_cycles  (word_cycles),
    .cs_evt_valid (cs_evt_valid),
    .cs_evt_prev  (cs_evt_prev),
    .cs_evt_now   (cs_evt_now)
);

// File: tb/tb_spi_bus_monitor.sv
module tb_spi_bus_monitor;
    localparam int CLK_PERIOD = 10;
    localparam int H = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_cpol = 0, cfg_cpha = 0, cfg_cs_act_high = 0, cfg_lsb_first = 0;
    logic [4:0] cfg_word_len = 5'd8;
    logic cfg_mosi_present = 1, cfg_miso_present = 1, cfg_cs_present = 1;
    logic spi_sclk = 0, spi_cs = 1, spi_mosi = 0, spi_miso = 0;
    logic word_valid, word_mosi_ok, word_miso_ok, word_warn, cs_evt_valid;
    logic [15:0] word_mosi, word_miso;
    logic [23:0] word_cycles;
    logic [1:0]  cs_evt_prev, cs_evt_now;

    int n_chk = 0, n_fail = 0;
    int n_words = 0, n_evt = 0, run = 0, max_run = 0;
    logic [15:0] l_mosi, l_miso;
    logic l_mosi_ok, l_miso_ok, l_warn;
    logic [23:0] l_cyc;
    logic [1:0] e_prev, e_now;
    logic b_lsb = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_bus_monitor dut (.*);

    always @(negedge clk) begin
        if (word_valid) begin
            n_words++;
            run++;
            if (run > max_run) max_run = run;
            l_mosi = word_mosi; l_miso = word_miso;
            l_mosi_ok = word_mosi_ok; l_miso_ok = word_miso_ok;
            l_warn = word_warn; l_cyc = word_cycles;
        end else run = 0;
        if (cs_evt_valid) begin
            n_evt++;
            e_prev = cs_evt_prev; e_now = cs_evt_now;
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic deselect();
        spi_cs = ~cfg_cs_act_high; wait_cyc(6);
    endtask

    task automatic select();
        spi_cs = cfg_cs_act_high; wait_cyc(6);
    endtask

    task automatic set_mode(input logic pol, input logic pha);
        deselect();
        cfg_cpol = pol; cfg_cpha = pha; spi_sclk = pol;
        wait_cyc(6);
        select();
    endtask

    task automatic xfer_part(input int n, input logic [15:0] mo, input logic [15:0] mi,
                             input int from, input int upto);
        for (int i = from; i < upto; i++) begin
            automatic int idx = b_lsb ? i : n - 1 - i;
            if (!cfg_cpha) begin
                spi_mosi = mo[idx]; spi_miso = mi[idx];
                wait_cyc(H); spi_sclk = ~cfg_cpol;
                wait_cyc(H); spi_sclk = cfg_cpol;
            end else begin
                spi_sclk = ~cfg_cpol; spi_mosi = mo[idx]; spi_miso = mi[idx];
                wait_cyc(H); spi_sclk = cfg_cpol;
                wait_cyc(H);
            end
        end
    endtask

    task automatic send_word(input string req, input int n,
                             input logic [15:0] mo, input logic [15:0] mi);
        automatic int w0 = n_words;
        xfer_part(n, mo, mi, 0, n);
        wait_cyc(12);
        chk(req, "word count", n_words - w0, 1);
        chk(req, "mosi word", l_mosi, mo);
        chk(req, "miso word", l_miso, mi);
        chk("R8", "warn clear", l_warn, 0);
    endtask

    task automatic t_reset();
        wait_cyc(3);
        chk("R11", "word_valid in reset", word_valid, 0);
        chk("R11", "cs_evt_valid in reset", cs_evt_valid, 0);
        rst_n = 1'b1;
        wait_cyc(12);
        chk("R6", "startup event count", n_evt, 1);
        chk("R6", "startup prev", e_prev, 2'b10);
        chk("R6", "startup now", e_now, 2'b01);
    endtask

    task automatic t_modes();
        for (int m = 0; m < 4; m++) begin
            set_mode(m[1], m[0]);
            send_word("R1", 8, 16'(8'hA5 ^ m), 16'(8'h3C + m));
            chk("R9", "cycle count", l_cyc, (8 - 1) * 2 * H + 1);
            chk("R7", "flags", {l_mosi_ok, l_miso_ok}, 2'b11);
        end
        set_mode(0, 0);
    endtask

    task automatic t_events();
        automatic int e0 = n_evt;
        deselect();
        chk("R5", "deselect event", n_evt - e0, 1);
        chk("R5", "deselect codes", {e_prev, e_now}, 4'b0001);
        select();
        chk("R5", "select codes", {e_prev, e_now}, 4'b0100);
    endtask

    task automatic t_order();
        deselect(); cfg_lsb_first = 1; b_lsb = 1; select();
        send_word("R2", 8, 16'h00B2, 16'h0017);
        deselect(); cfg_lsb_first = 0; b_lsb = 0; select();
        send_word("R2", 8, 16'h00B2, 16'h0017);
    endtask

    task automatic t_len();
        deselect(); cfg_word_len = 5'd12; select();
        send_word("R3", 12, 16'h0ABC, 16'h0123);
        deselect(); cfg_word_len = 5'd0; select();
        send_word("R3", 16, 16'hBEEF, 16'h8001);
        deselect(); cfg_word_len = 5'd8; select();
    endtask

    task automatic t_discard();
        automatic int w0 = n_words;
        xfer_part(8, 16'hFF, 16'hFF, 0, 3);
        deselect(); select();
        xfer_part(8, 16'hA5, 16'h5A, 0, 8);
        wait_cyc(12);
        chk("R5", "one word after cut", n_words - w0, 1);
        chk("R5", "partial discarded", l_mosi, 16'hA5);
    endtask

    task automatic t_cfg_hold();
        automatic int w0 = n_words;
        xfer_part(8, 16'hC3, 16'h81, 0, 4);
        cfg_lsb_first = 1; cfg_cpha = 1; cfg_word_len = 5'd4;
        wait_cyc(4);
        cfg_cpha = 0;
        xfer_part(8, 16'hC3, 16'h81, 4, 8);
        wait_cyc(12);
        chk("R10", "word count", n_words - w0, 1);
        chk("R10", "mosi unchanged order", l_mosi, 16'hC3);
        deselect(); cfg_lsb_first = 0; cfg_word_len = 5'd8; select();
    endtask

    task automatic t_polarity();
        automatic int w0;
        deselect();
        cfg_cs_act_high = 1; wait_cyc(6);
        send_word("R4", 8, 16'h96, 16'h69);
        spi_cs = 0; wait_cyc(6);
        w0 = n_words;
        xfer_part(8, 16'h55, 16'h55, 0, 8);
        wait_cyc(12);
        chk("R4", "no word while inactive", n_words - w0, 0);
        cfg_cs_act_high = 0; spi_cs = 1; wait_cyc(6);
        select();
    endtask

    task automatic t_absent_line();
        deselect(); cfg_miso_present = 0; select();
        xfer_part(8, 16'h5A, 16'hFF, 0, 8);
        wait_cyc(12);
        chk("R7", "miso zero", l_miso, 0);
        chk("R7", "miso flag", l_miso_ok, 0);
        chk("R7", "mosi kept", l_mosi, 16'h5A);
        chk("R7", "mosi flag", l_mosi_ok, 1);
        deselect(); cfg_miso_present = 1; select();
    endtask

    task automatic t_warn();
        automatic int w0, e0;
        deselect(); cfg_word_len = 5'd1; select();
        w0 = n_words; e0 = n_evt;
        spi_mosi = 1; spi_miso = 0; wait_cyc(H);
        spi_sclk = 1; spi_cs = 1;
        wait_cyc(12);
        chk("R8", "word count", n_words - w0, 1);
        chk("R8", "warn set", l_warn, 1);
        chk("R8", "bit value", l_mosi, 1);
        chk("R8", "cycles one bit", l_cyc, 1);
        chk("R5", "release event", n_evt - e0, 1);
        spi_sclk = 0; wait_cyc(6);
        cfg_word_len = 5'd8; wait_cyc(4);
    endtask

    task automatic t_no_cs();
        automatic int e0;
        rst_n = 0; cfg_cs_present = 0; spi_cs = 1; wait_cyc(4);
        e0 = n_evt;
        rst_n = 1; wait_cyc(12);
        chk("R6", "absent startup count", n_evt - e0, 1);
        chk("R6", "absent startup codes", {e_prev, e_now}, 4'b1011);
        send_word("R6", 8, 16'h69, 16'hE1);
        e0 = n_evt;
        spi_cs = 0; wait_cyc(6); spi_cs = 1; wait_cyc(6);
        chk("R6", "no event when absent", n_evt - e0, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        report();
        $finish;
    end

    initial begin
        t_reset();
        t_modes();
        t_events();
        t_order();
        t_len();
        t_discard();
        t_cfg_hold();
        t_polarity();
        t_absent_line();
        t_warn();
        t_no_cs();
        chk("R11", "word_valid pulse width", max_run, 1);
        report();
        $finish;
    end
endmodule